// File: doc/BRIEF.md
# UART Modem Status and Loopback

This block holds the modem-side control and status state of a 16550-style serial port. Four handshake inputs arrive asynchronously: carrier detect, ring indicator, data-set ready and clear-to-send. Each one passes through a synchronizer before any change detection. The block keeps the current level of each input and a sticky change flag for each. Software reads both as one status byte through a read strobe, and that read clears the change flags.

A 5-bit control register drives the four modem outputs and selects loopback. In loopback the status byte shows the control outputs in place of the external inputs, the change flags are hidden, and the external output pins go inactive. A single any-change flag goes to the interrupt logic. All status and control signals are active-high here, so 1 means asserted.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, msr_o reads 0xB0 (carrier, data-set ready and clear-to-send asserted, no change flags), mcr_o reads 0x08, out2_o is 1, rts_o, dtr_o and out1_o are 0, and delta_any_o is 0.
- R2: Outside loopback, msr_o bits 7, 6, 5 and 4 show the synchronized dcd_i, ri_i, dsr_i and cts_i. A level driven before clock edge k is visible after edge k+2.
- R3: Any change in either direction of dcd_i, dsr_i or cts_i sets msr_o bit 3, 1 or 0 respectively, in the same cycle that the new level appears in the upper nibble.
- R4: msr_o bit 2 is set only when ri_i falls from 1 to 0. A rising ri_i leaves it clear.
- R5: Change flags stay set, whatever the inputs do, until a status read clears them.
- R6: While msr_re_i is high, msr_o shows the full status byte. Outside loopback the change flags then read 0 from the next cycle, except a flag whose change lands on that same clock edge, which is kept.
- R7: A write with mcr_we_i stores mcr_wdata_i bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback). mcr_o returns them in the next cycle with bits 7:5 reading 0.
- R8: Outside loopback, dtr_o, rts_o, out1_o and out2_o follow control bits 0, 1, 2 and 3.
- R9: In loopback, msr_o bit 7 shows OUT2, bit 6 OUT1, bit 5 DTR and bit 4 RTS, and bits 3:0 read 0. The external inputs are still tracked, a read does not clear the flags, and any flags held become visible again on leaving loopback.
- R10: In loopback, dtr_o, rts_o, out1_o and out2_o are all 0.
- R11: delta_any_o is the OR of msr_o bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| ri_i | input | 1 | Ring indicator input, asynchronous |
| dcd_i | input | 1 | Carrier detect input, asynchronous |
| mcr_we_i | input | 1 | Control register write strobe |
| mcr_wdata_i | input | 8 | Control register write data |
| msr_re_i | input | 1 | Status read strobe; clears change flags |
| mcr_o | output | 8 | Control register read value |
| msr_o | output | 8 | Status byte read value |
| dtr_o | output | 1 | Data-terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | General output 1 pin |
| out2_o | output | 1 | General output 2 pin |
| delta_any_o | output | 1 | Any change flag pending |

## Verification
The inputs are toggled one at a time in both directions. This shows that each line sets only its own flag, that ring sets its flag on the falling edge alone, and that flags accumulate across several lines until a read. One case lands a change on the same edge as a read strobe, which separates a read that drops the new change from one that keeps it. Loopback is checked with two control patterns that map each output onto a distinct status bit, and with an external change made while loopback is on, whose flag has to stay hidden and then reappear when loopback is switched off.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned NLINES = 4;
  localparam int unsigned MCR_W  = 5;
  // status nibble order: [3]=dcd [2]=ri [1]=dsr [0]=cts
  localparam int unsigned S_CTS = 0;
  localparam int unsigned S_DSR = 1;
  localparam int unsigned S_RI  = 2;
  localparam int unsigned S_DCD = 3;
  // control bits
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;
  localparam logic [NLINES-1:0] STAT_RST = 4'b1011;
  localparam logic [MCR_W-1:0]  MCR_RST  = 5'b01000;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [MCR_W-1:0] ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= MCR_RST;
    else if (we_i) ctl_o <= wdata_i[MCR_W-1:0];
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lines_i,
  input  logic              rd_clr_i,
  output logic [NLINES-1:0] stat_o,
  output logic [NLINES-1:0] delta_o
);
  logic [NLINES-1:0] chg, set_v, delta_d;

  assign chg = stat_o ^ lines_i;

  // ring flag only on a 1 -> 0 transition
  always_comb begin
    set_v        = chg;
    set_v[S_RI]  = chg[S_RI] & stat_o[S_RI];
    delta_d      = (rd_clr_i ? '0 : delta_o) | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o  <= STAT_RST;
      delta_o <= '0;
    end else begin
      stat_o  <= lines_i;
      delta_o <= delta_d;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          dcd_i,
  input  logic          mcr_we_i,
  input  logic [DW-1:0] mcr_wdata_i,
  input  logic          msr_re_i,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] msr_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          delta_any_o
);
  localparam int unsigned PAD_W = DW - MCR_W;

  logic [NLINES-1:0] raw_v, sync_v, stat_v, delta_v, loop_v;
  logic [MCR_W-1:0]  ctl;
  logic              loop;

  always_comb begin
    raw_v        = '0;
    raw_v[S_CTS] = cts_i;
    raw_v[S_DSR] = dsr_i;
    raw_v[S_RI]  = ri_i;
    raw_v[S_DCD] = dcd_i;
  end

  mdm_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(STAT_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_v), .q_o(sync_v)
  );

  mdm_ctrl_reg #(.DW(DW)) u_ctl (
    .clk_i, .rst_ni, .we_i(mcr_we_i), .wdata_i(mcr_wdata_i), .ctl_o(ctl)
  );

  assign loop = ctl[C_LOOP];

  mdm_status u_stat (
    .clk_i, .rst_ni, .lines_i(sync_v), .rd_clr_i(msr_re_i & ~loop),
    .stat_o(stat_v), .delta_o(delta_v)
  );

  always_comb begin
    loop_v        = '0;
    loop_v[S_DCD] = ctl[C_OUT2];
    loop_v[S_RI]  = ctl[C_OUT1];
    loop_v[S_DSR] = ctl[C_DTR];
    loop_v[S_CTS] = ctl[C_RTS];
  end

  assign msr_o       = loop ? {loop_v, {NLINES{1'b0}}} : {stat_v, delta_v};
  assign mcr_o       = {{PAD_W{1'b0}}, ctl};
  assign delta_any_o = ~loop & (|delta_v);
  assign dtr_o       = ~loop & ctl[C_DTR];
  assign rts_o       = ~loop & ctl[C_RTS];
  assign out1_o      = ~loop & ctl[C_OUT1];
  assign out2_o      = ~loop & ctl[C_OUT2];
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mcr_we_i,
  input logic       msr_re_i,
  input logic [7:0] mcr_o,
  input logic [7:0] msr_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       delta_any_o
);
  AST_MCR_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[7:5] == 3'b000); // R7

  AST_PINS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcr_o[4] |-> ({out2_o, out1_o, rts_o, dtr_o} == mcr_o[3:0])); // R8

  AST_LOOP_PINS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[4] |-> !(dtr_o | rts_o | out1_o | out2_o)); // R10

  AST_LOOP_NO_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[4] |-> (msr_o[3:0] == 4'h0)); // R9

  AST_STICKY_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msr_re_i && !mcr_we_i && !mcr_o[4] && msr_o[0]) |=> msr_o[0]); // R5

  AST_TERI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcr_o[4] && $past(!mcr_o[4]) && $rose(msr_o[2])) |-> $fell(msr_o[6])); // R4

  AST_ANY_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_any_o == (|msr_o[3:0])); // R11
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (.*);

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic       mcr_we_i = 1'b0;
  logic [7:0] mcr_wdata_i = 8'h00;
  logic       msr_re_i = 1'b0;
  logic [7:0] mcr_o, msr_o;
  logic       dtr_o, rts_o, out1_o, out2_o, delta_any_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  uart_modem_ctl u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // three edges from input change to visible status
  task automatic settle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd_msr(input logic [7:0] exp, input string req);
    @(negedge clk_i);
    msr_re_i = 1'b1;
    #1 chk(msr_o, exp, req);
    @(negedge clk_i);
    msr_re_i = 1'b0;
  endtask

  task automatic wr_mcr(input logic [7:0] v);
    @(negedge clk_i);
    mcr_we_i = 1'b1; mcr_wdata_i = v;
    @(negedge clk_i);
    mcr_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(msr_o, 8'hB0, "R1 msr");
    chk(mcr_o, 8'h08, "R1 mcr");
    chk({4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h08, "R1 pins");
    chk({7'h0, delta_any_o}, 8'h00, "R1 any");
  endtask

  task automatic t_cts_sticky_read();
    @(negedge clk_i); cts_i = 1'b0;
    settle();
    chk(msr_o, 8'hA1, "R2 R3 cts low");
    chk({7'h0, delta_any_o}, 8'h01, "R11 any set");
    repeat (5) @(negedge clk_i);
    chk(msr_o, 8'hA1, "R5 sticky");
    rd_msr(8'hA1, "R6 read value");
    chk(msr_o, 8'hA0, "R6 cleared");
    chk({7'h0, delta_any_o}, 8'h00, "R11 any clear");
  endtask

  task automatic t_ring();
    @(negedge clk_i); ri_i = 1'b1;
    settle();
    chk(msr_o, 8'hE0, "R4 ring rise no flag");
    @(negedge clk_i); ri_i = 1'b0;
    settle();
    chk(msr_o, 8'hA4, "R4 ring fall flag");
    rd_msr(8'hA4, "R6 read ring");
    chk(msr_o, 8'hA0, "R6 ring cleared");
  endtask

  task automatic t_multi();
    @(negedge clk_i); dcd_i = 1'b0;
    settle();
    chk(msr_o, 8'h28, "R3 dcd fall");
    @(negedge clk_i); dsr_i = 1'b0;
    settle();
    chk(msr_o, 8'h0A, "R3 R5 dsr fall accumulate");
    rd_msr(8'h0A, "R6 read multi");
    @(negedge clk_i); dcd_i = 1'b1; dsr_i = 1'b1; cts_i = 1'b1;
    settle();
    chk(msr_o, 8'hBB, "R3 rising edges");
    rd_msr(8'hBB, "R6 read rising");
    chk(msr_o, 8'hB0, "R6 rising cleared");
  endtask

  task automatic t_read_collide();
    @(negedge clk_i); cts_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i); msr_re_i = 1'b1;
    @(negedge clk_i); msr_re_i = 1'b0;
    chk(msr_o, 8'hA1, "R6 change on read edge kept");
    rd_msr(8'hA1, "R6 read collide");
    @(negedge clk_i); cts_i = 1'b1;
    settle();
    rd_msr(8'hB1, "R3 cts rise");
    chk(msr_o, 8'hB0, "R6 clear after rise");
  endtask

  task automatic t_mcr();
    wr_mcr(8'hEF);
    chk(mcr_o, 8'h0F, "R7 store low bits");
    chk({4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h0F, "R8 pins all");
    wr_mcr(8'h05);
    chk(mcr_o, 8'h05, "R7 pattern 05");
    chk({4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h05, "R8 pins 05");
  endtask

  task automatic t_loop();
    wr_mcr(8'h1A);
    chk(mcr_o, 8'h1A, "R7 loop set");
    chk({4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h00, "R10 pins off");
    chk(msr_o, 8'h90, "R9 map out2 rts");
    wr_mcr(8'h15);
    chk(msr_o, 8'h60, "R9 map out1 dtr");
    @(negedge clk_i); cts_i = 1'b0;
    settle();
    chk(msr_o, 8'h60, "R9 external hidden");
    chk({7'h0, delta_any_o}, 8'h00, "R9 R11 any masked");
    rd_msr(8'h60, "R9 read in loop");
    wr_mcr(8'h08);
    chk(msr_o, 8'hA1, "R9 held flag after exit");
    chk({4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h08, "R8 pins after exit");
    rd_msr(8'hA1, "R6 read after exit");
    chk(msr_o, 8'hA0, "R6 cleared after exit");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cts_sticky_read();
    t_ring();
    t_multi();
    t_read_collide();
    t_mcr();
    t_loop();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule